// File: doc/BRIEF.md
# Programmable 5-Bit PWM Generator

This block produces a fixed-frequency pulse-width-modulated level from a 5-bit duty code. Each output period is 32 steps long, and a step lasts a whole number of system clocks. Four step divisors are parameters and a 2-bit rate select chooses among them, so one build can serve 1, 5, 10 and 100 kHz outputs. The output is high during the first `code` steps of each period. Code 0 keeps it low. Code 31 keeps it high for 31 of the 32 steps.

A command decoder drives the block through one-cycle strobes. One strobe writes a new duty code. Another selects full-on, which holds the output high for the whole period whatever the code is. A shutdown strobe drops the output enable so that the pin floats, and a recall strobe brings the output back with the setting it had before. Duty and full-on commands go to a shadow register. They reach the output only when a new period opens, so no period is ever cut short. The shadow setting and the shutdown flag are brought out for readback.

Top module: `pwm5_gen`

## Requirements
- R1: After reset the shadow and active code is 16 (binary 10000), full-on is clear and shutdown is clear, so the output enable is high and every period is high for exactly 16 of its 32 steps.
- R2: With active code d and full-on clear, the output is high for the first d steps of every period and low for the remaining 32-d. Code 0 gives no high step and code 31 gives 31 high steps.
- R3: A full-on command holds the output high for all 32 steps, whatever the code is. A later duty write clears full-on.
- R4: A duty or full-on command takes effect from the first period that opens after the clock edge that registers it. The period in progress keeps its old shape. A command registered on the edge that opens a period therefore waits for the following period.
- R5: A shutdown command forces the output enable low and the output level low from the next clock onward.
- R6: A recall command raises the output enable on the next clock. The output then resumes with the duty and full-on setting held before the shutdown.
- R7: A duty or full-on command is dropped when the shutdown flag is set, or when it arrives in the same cycle as a shutdown command.
- R8: When shutdown and recall arrive in the same cycle, shutdown wins and the block stays shut down.
- R9: Rate select values 0, 1, 2 and 3 pick step divisors STEP_DIV_A, STEP_DIV_B, STEP_DIV_C and STEP_DIV_D in that order. One period lasts 32 times the selected divisor in clocks.
- R10: The readback ports show the shadow code, the shadow full-on flag and the shutdown flag one clock after the edge that registers a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel | input | 2 | Selects one of the four step divisors |
| duty_wr | input | 1 | Strobe: load duty_in into the shadow code and clear full-on |
| duty_in | input | 5 | New duty code |
| full_on_cmd | input | 1 | Strobe: set full-on in the shadow setting |
| shutdown_cmd | input | 1 | Strobe: enter shutdown |
| recall_cmd | input | 1 | Strobe: leave shutdown |
| pwm_out | output | 1 | Modulated level |
| pwm_oe | output | 1 | Output enable; low means the pin floats |
| rd_duty | output | 5 | Readback of the shadow code |
| rd_full_on | output | 1 | Readback of the shadow full-on flag |
| rd_shutdown | output | 1 | Readback of the shutdown flag |

## Verification
Readback values and the effects of shutdown and recall are due in the first cycle after the edge that registers the strobe. The bench checks them right after that edge, before any further stimulus. A duty or full-on change is due in the period after the edge that registers it. The bench keeps its own cycle count from reset release and derives the period windows from the selected divisor. For each command it queues the expected high count and enable count of the affected periods, and the monitor compares these with totals measured over exactly those windows. Commands are placed both in mid-period and on the edge that opens a period, so both sides of the update boundary are covered.

// File: rtl/pwm5_pkg.sv
`timescale 1ns/1ps
// Shared widths, types and reset constants for the 5-bit PWM generator.
// Assumes a power-of-two step count per period.
package pwm5_pkg;
    parameter int DUTY_W    = 5;
    parameter int STEPS     = 1 << DUTY_W;
    parameter int SEL_W     = 2;
    parameter int NUM_RATES = 1 << SEL_W;

    typedef logic [DUTY_W-1:0] duty_t;

    // Mid-scale code loaded by reset (50 % duty)
    parameter duty_t DUTY_RESET = duty_t'(STEPS / 2);

    // A complete output setting: full-on flag plus duty code
    typedef struct packed {
        logic  full;
        duty_t code;
    } pwm_set_t;
endpackage

// File: rtl/pwm5_step_tick.sv
`timescale 1ns/1ps
// Step-enable generator. Emits a one-clock tick every DIV clocks, where DIV
// is one of four parameterised divisors picked by rate_sel.
// Assumes every divisor is at least 1. If rate_sel changes mid-count, the
// counter wraps at the new limit, or at once if it is already past it.
module pwm5_step_tick
    import pwm5_pkg::*;
#(
    parameter int unsigned DIV_A = 6250,
    parameter int unsigned DIV_B = 1250,
    parameter int unsigned DIV_C = 625,
    parameter int unsigned DIV_D = 62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             step_tick
);
    function automatic int unsigned div_of(input int idx);
        case (idx)
            0:       return DIV_A;
            1:       return DIV_B;
            2:       return DIV_C;
            default: return DIV_D;
        endcase
    endfunction

    function automatic int unsigned div_max();
        int unsigned m;
        m = 1;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (div_of(i) > m) m = div_of(i);
        end
        return m;
    endfunction

    localparam int unsigned DIV_MAX = div_max();
    localparam int CNT_W = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

    logic [NUM_RATES-1:0][CNT_W-1:0] lim_tab;
    logic [CNT_W-1:0]                lim;
    logic [CNT_W-1:0]                cnt_q;

    // Terminal-count table, one entry per rate
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'(div_of(g) - 1);
    end

    assign lim       = lim_tab[rate_sel];
    assign step_tick = (cnt_q >= lim);

    // Clock divider counter: wraps to zero on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (step_tick) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // R9
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && lim != '0) |=> (!step_tick || lim != $past(lim)));
endmodule

// File: rtl/pwm5_cmd_regs.sv
`timescale 1ns/1ps
// Command register file. Holds the shadow setting (code plus full-on) and
// the shutdown flag.
// Shutdown beats recall. Setting commands are dropped while shut down or
// when they arrive with a shutdown. A duty write clears full-on unless
// full-on arrives in the same cycle.
module pwm5_cmd_regs
    import pwm5_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     duty_wr,
    input  duty_t    duty_in,
    input  logic     full_cmd,
    input  logic     shut_cmd,
    input  logic     recall_cmd,
    output pwm_set_t shadow,
    output logic     shut
);
    logic take_set;

    assign take_set = !shut && !shut_cmd;

    // Shutdown flag: set by shutdown, cleared by recall, shutdown wins
    always_ff @(posedge clk) begin
        if (!rst_n)          shut <= 1'b0;
        else if (shut_cmd)   shut <= 1'b1;
        else if (recall_cmd) shut <= 1'b0;
    end

    // Shadow setting: accepts duty and full-on only while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '{full: 1'b0, code: DUTY_RESET};
        end else if (take_set) begin
            if (duty_wr) begin
                shadow.code <= duty_in;
                shadow.full <= full_cmd;
            end else if (full_cmd) begin
                shadow.full <= 1'b1;
            end
        end
    end

    // R5
    shut_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shut_cmd |=> shut);
    // R8
    recall_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_cmd && !shut_cmd) |=> !shut);
    // R7
    frozen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shut || shut_cmd) |=> $stable(shadow));
    // R3
    full_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_wr && !full_cmd && !shut && !shut_cmd) |=> !shadow.full);
endmodule

// File: rtl/pwm5_wave.sv
`timescale 1ns/1ps
// Waveform stage. It counts 32 steps per period, copies the shadow setting
// into the active setting at each period wrap, and compares the step count
// with the active code.
// Assumes step_tick is a one-clock enable. The outputs are built only from
// registers.
module pwm5_wave
    import pwm5_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step_tick,
    input  pwm_set_t shadow,
    input  logic     shut,
    output logic     pwm_out,
    output logic     pwm_oe
);
    duty_t    step_q;
    pwm_set_t act_q;
    logic     wrap;
    logic     level;

    assign wrap  = step_tick && (step_q == '1);
    assign level = act_q.full || (step_q < act_q.code);

    // Step counter: one increment per tick, wraps after the last step
    always_ff @(posedge clk) begin
        if (!rst_n)         step_q <= '0;
        else if (step_tick) step_q <= step_q + 1'b1;
    end

    // Active setting: reloaded from the shadow only at a period wrap
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '{full: 1'b0, code: DUTY_RESET};
        else if (wrap) act_q <= shadow;
    end

    assign pwm_oe  = !shut;
    assign pwm_out = !shut && level;

    // R5
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_oe |-> !pwm_out);
    // R4
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_q));
    // R3
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.full && pwm_oe) |-> pwm_out);
    // R2
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q.full && act_q.code == '0) |-> !pwm_out);
    // R2
    first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == '0 && act_q.code != '0 && pwm_oe) |-> pwm_out);
endmodule

// File: rtl/pwm5_gen.sv
`timescale 1ns/1ps
// Top of the 5-bit PWM generator: step divider, command registers and
// waveform stage.
// Assumes the command inputs are one-clock strobes, synchronous to clk.
module pwm5_gen
    import pwm5_pkg::*;
#(
    parameter int unsigned STEP_DIV_A = 6250,
    parameter int unsigned STEP_DIV_B = 1250,
    parameter int unsigned STEP_DIV_C = 625,
    parameter int unsigned STEP_DIV_D = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic              duty_wr,
    input  logic [4:0]        duty_in,
    input  logic              full_on_cmd,
    input  logic              shutdown_cmd,
    input  logic              recall_cmd,
    output logic              pwm_out,
    output logic              pwm_oe,
    output logic [4:0]        rd_duty,
    output logic              rd_full_on,
    output logic              rd_shutdown
);
    logic     step_tick;
    pwm_set_t shadow;
    logic     shut;

    pwm5_step_tick #(
        .DIV_A(STEP_DIV_A), .DIV_B(STEP_DIV_B),
        .DIV_C(STEP_DIV_C), .DIV_D(STEP_DIV_D)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .step_tick (step_tick)
    );

    pwm5_cmd_regs u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .duty_wr    (duty_wr),
        .duty_in    (duty_in),
        .full_cmd   (full_on_cmd),
        .shut_cmd   (shutdown_cmd),
        .recall_cmd (recall_cmd),
        .shadow     (shadow),
        .shut       (shut)
    );

    pwm5_wave u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .shadow    (shadow),
        .shut      (shut),
        .pwm_out   (pwm_out),
        .pwm_oe    (pwm_oe)
    );

    assign rd_duty     = shadow.code;
    assign rd_full_on  = shadow.full;
    assign rd_shutdown = shut;
endmodule

// File: tb/pwm5_gen_tb.sv
`timescale 1ns/1ps
module pwm5_gen_tb;
    localparam int DA = 2, DB = 3, DC = 4, DD = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       duty_wr = 1'b0;
    logic [4:0] duty_in = 5'd0;
    logic       full_on_cmd = 1'b0;
    logic       shutdown_cmd = 1'b0;
    logic       recall_cmd = 1'b0;
    logic       pwm_out, pwm_oe, rd_full_on, rd_shutdown;
    logic [4:0] rd_duty;

    always #2.5 clk = ~clk;

    pwm5_gen #(.STEP_DIV_A(DA), .STEP_DIV_B(DB), .STEP_DIV_C(DC), .STEP_DIV_D(DD)) u_dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .duty_wr(duty_wr),
        .duty_in(duty_in), .full_on_cmd(full_on_cmd), .shutdown_cmd(shutdown_cmd),
        .recall_cmd(recall_cmd), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
        .rd_duty(rd_duty), .rd_full_on(rd_full_on), .rd_shutdown(rd_shutdown)
    );

    typedef struct { int per; int high; int oe; string req; } exp_t;
    exp_t sb_q[$];

    int n_chk = 0, n_err = 0;
    int tcnt = 0;
    int cur_div = DA;
    int acc_hi = 0, acc_oe = 0;
    int mon_p;
    exp_t mon_e;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Cycle count since reset release; interval 0 follows the release
    always @(posedge clk) begin
        if (!rst_n) tcnt <= 0;
        else        tcnt <= tcnt + 1;
    end

    // Monitor: totals per period window, compared with queued expectations
    always @(negedge clk) begin
        if (!rst_n) begin
            acc_hi = 0;
            acc_oe = 0;
        end else begin
            acc_hi += int'(pwm_out);
            acc_oe += int'(pwm_oe);
            if (tcnt % (32 * cur_div) == 32 * cur_div - 1) begin
                mon_p = tcnt / (32 * cur_div);
                if (sb_q.size() > 0 && sb_q[0].per <= mon_p) begin
                    mon_e = sb_q.pop_front();
                    chk(mon_e.per == mon_p, mon_e.req, "period index", mon_p, mon_e.per);
                    chk(acc_hi == mon_e.high, mon_e.req, "high cycles", acc_hi, mon_e.high);
                    chk(acc_oe == mon_e.oe, mon_e.req, "enabled cycles", acc_oe, mon_e.oe);
                end
                acc_hi = 0;
                acc_oe = 0;
            end
        end
    end

    task automatic push(input int per, input int steps_hi, input bit on, input string req);
        exp_t e;
        e.per  = per;
        e.high = steps_hi * cur_div;
        e.oe   = on ? 32 * cur_div : 0;
        e.req  = req;
        sb_q.push_back(e);
    endtask

    task automatic wait_t(input int tt);
        do begin
            @(posedge clk);
            #1;
        end while (tcnt != tt);
    endtask

    // Drive one strobe set during interval tt; it is registered at the edge ending tt
    task automatic issue(input int tt, input bit wr, input int d, input bit fo, input bit sd, input bit rc);
        wait_t(tt);
        duty_wr = wr; duty_in = 5'(d); full_on_cmd = fo; shutdown_cmd = sd; recall_cmd = rc;
        @(posedge clk);
        #1;
        duty_wr = 1'b0; full_on_cmd = 1'b0; shutdown_cmd = 1'b0; recall_cmd = 1'b0;
    endtask

    task automatic reset_to(input int sel, input int div);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        rate_sel = 2'(sel);
        cur_div = div;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && sb_q.size() > 0; i++) @(posedge clk);
        chk(sb_q.size() == 0, "R9", "pending expectations", sb_q.size(), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        int p;
        reset_to(0, DA);
        p = 32 * DA;
        // R1: reset state
        chk(rd_duty == 5'd16, "R1", "rd_duty", rd_duty, 16);
        chk(rd_full_on == 1'b0, "R1", "rd_full_on", rd_full_on, 0);
        chk(rd_shutdown == 1'b0, "R1", "rd_shutdown", rd_shutdown, 0);
        chk(pwm_oe == 1'b1, "R1", "pwm_oe", pwm_oe, 1);
        push(0, 16, 1, "R1");
        push(1, 16, 1, "R4");
        // R2, R10: code 0 written mid-period
        issue(p + 5, 1, 0, 0, 0, 0);
        chk(rd_duty == 5'd0, "R10", "rd_duty", rd_duty, 0);
        push(2, 0, 1, "R2");
        // R4: write registered on the edge that opens period 3
        issue(3 * p - 1, 1, 31, 0, 0, 0);
        push(3, 0, 1, "R4");
        push(4, 31, 1, "R2");
        // R3: full-on
        issue(4 * p + 10, 0, 0, 1, 0, 0);
        chk(rd_full_on == 1'b1, "R10", "rd_full_on", rd_full_on, 1);
        push(5, 32, 1, "R3");
        // R3: duty write cancels full-on
        issue(5 * p + 3, 1, 7, 0, 0, 0);
        chk(rd_full_on == 1'b0, "R3", "rd_full_on after write", rd_full_on, 0);
        push(6, 7, 1, "R3");
        // R5: shutdown from next clock
        issue(7 * p - 1, 0, 0, 0, 1, 0);
        chk(pwm_oe == 1'b0, "R5", "pwm_oe", pwm_oe, 0);
        chk(rd_shutdown == 1'b1, "R5", "rd_shutdown", rd_shutdown, 1);
        push(7, 0, 0, "R5");
        // R7: commands dropped while shut down
        issue(7 * p + 5, 1, 3, 0, 0, 0);
        chk(rd_duty == 5'd7, "R7", "rd_duty in shutdown", rd_duty, 7);
        issue(7 * p + 9, 0, 0, 1, 0, 0);
        chk(rd_full_on == 1'b0, "R7", "rd_full_on in shutdown", rd_full_on, 0);
        // R8: shutdown beats recall
        issue(7 * p + 20, 0, 0, 0, 1, 1);
        chk(rd_shutdown == 1'b1, "R8", "rd_shutdown", rd_shutdown, 1);
        chk(pwm_oe == 1'b0, "R8", "pwm_oe", pwm_oe, 0);
        push(8, 0, 0, "R8");
        // R6: recall restores code 7
        issue(9 * p - 1, 0, 0, 0, 0, 1);
        chk(pwm_oe == 1'b1, "R6", "pwm_oe", pwm_oe, 1);
        chk(pwm_out == 1'b1, "R6", "pwm_out step 0", pwm_out, 1);
        push(9, 7, 1, "R6");
        // R6: full-on survives shutdown and recall
        issue(9 * p + 4, 0, 0, 1, 0, 0);
        push(10, 32, 1, "R3");
        issue(11 * p - 1, 0, 0, 0, 1, 0);
        push(11, 0, 0, "R5");
        issue(12 * p - 1, 0, 0, 0, 0, 1);
        push(12, 32, 1, "R6");
        issue(12 * p + 2, 1, 16, 0, 0, 0);
        push(13, 16, 1, "R2");
        drain();

        // R9: other rates
        reset_to(2, DC);
        push(0, 16, 1, "R9");
        issue(10, 1, 5, 0, 0, 0);
        push(1, 5, 1, "R9");
        drain();

        reset_to(3, DD);
        push(0, 16, 1, "R9");
        issue(30, 1, 1, 0, 0, 0);
        push(1, 1, 1, "R9");
        drain();

        reset_to(1, DB);
        push(0, 16, 1, "R9");
        issue(40, 1, 31, 0, 0, 0);
        push(1, 31, 1, "R9");
        drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule